// File: doc/BRIEF.md
# Alignment Trap Entry State Update

This block makes the architectural register changes that a processor performs when it takes a trap for a misaligned data access. The pipeline raises a one-cycle take strobe. In that same cycle the block tells the pipeline to squash the offending instruction, so that instruction never completes. On the clock edge where the strobe is high, the block records three values:

- the instruction address of the offender;
- the complete machine-state word as it was before the trap;
- the data address that the offender computed.

On that edge it also writes a filtered machine-state word and forms the fetch address of the handler.

In the next cycle a one-cycle redirect pulse tells the fetch unit to jump to that address. A small two-state controller sequences the work. Its states are `ST_IDLE` and `ST_REDIRECT`. Its transitions are:

- `ST_IDLE` to `ST_REDIRECT` on the strobe;
- `ST_REDIRECT` to `ST_REDIRECT` on a back-to-back strobe;
- `ST_REDIRECT` to `ST_IDLE` when no strobe arrives.

Top module: `align_trap_unit`

## Requirements
- R1: A synchronous active-high reset drives every output register (saved PC, saved state, fault address, new state, target) to zero and puts the controller in `ST_IDLE`, so the redirect output is low.
- R2: `squash_o` is high in exactly the cycles where `take_i` is high, with no delay.
- R3: After a clock edge with `take_i` high, `saved_pc_o` equals the `inst_ea_i` value present at that edge.
- R4: After a strobe edge, `saved_msr_o` equals the full `msr_i` value present at that edge, with every bit kept.
- R5: After a strobe edge, `msr_o` keeps `msr_i` bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable), and every other bit is 0.
- R6: After a strobe edge, `fault_addr_o` equals `data_ea_i` exactly, and its low bits are not aligned away.
- R7: After a strobe edge, `target_o` equals `{vec_prefix_i[15:0], vec_offset_i[11:0], 4'b0000}`.
- R8: `redirect_o` is high in the cycle after each strobe cycle, and is low in every cycle whose previous cycle had no strobe.
- R9: Edges without a strobe leave all five output registers unchanged, even when the data inputs change.
- R10: Two strobes in consecutive cycles each capture their own inputs. The second overwrites the first, and `redirect_o` stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take_i | input | 1 | One-cycle strobe to take the alignment trap |
| inst_ea_i | input | 32 | Address of the faulting instruction |
| data_ea_i | input | 32 | Data address computed by the faulting instruction |
| msr_i | input | 32 | Current machine-state word |
| vec_prefix_i | input | 16 | Upper prefix field of the vector base |
| vec_offset_i | input | 12 | Offset field for this trap |
| squash_o | output | 1 | Suppress completion of the faulting instruction |
| saved_pc_o | output | 32 | Saved instruction address |
| saved_msr_o | output | 32 | Saved machine-state word |
| fault_addr_o | output | 32 | Captured data fault address |
| msr_o | output | 32 | Filtered machine-state word |
| redirect_o | output | 1 | Fetch redirect pulse |
| target_o | output | 32 | Handler fetch address |

## Verification
Some properties are checked on every cycle:

- every strobe is followed by a redirect, and no redirect appears without a strobe;
- the saved PC, the saved state and the fault address match the inputs seen at the strobe edge;
- the new state word has no bits set outside the three kept enables;
- the target ends in four zero bits;
- all capture registers hold their values on edges without a strobe.

Other behaviour only the directed scenarios can show: the exact value of the composed vector, that the kept enable bits pass through with their true values, the zero state after reset, and the overwrite order when two strobes arrive back to back.

// File: rtl/atu_pkg.sv
package atu_pkg;
    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_REDIRECT = 1'b1
    } atu_state_e;

    function automatic logic [31:0] keep_mask(input int ce_pos, input int me_pos, input int de_pos);
        logic [31:0] m;
        m = '0;
        m[ce_pos] = 1'b1;
        m[me_pos] = 1'b1;
        m[de_pos] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/atu_ctrl.sv
module atu_ctrl
    import atu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    output logic capture_o,
    output logic squash_o,
    output logic redirect_o
);
    atu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (take_i) state_d = ST_REDIRECT;
            ST_REDIRECT: state_d = take_i ? ST_REDIRECT : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o  = take_i;
        squash_o   = take_i;
        redirect_o = (state_q == ST_REDIRECT);
    end

    AST_REDIRECT_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (rst)
        take_i |=> redirect_o); // R8
    AST_REDIRECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> $past(take_i)); // R8
endmodule

// File: rtl/atu_msr_filter.sv
module atu_msr_filter #(
    parameter int          MSR_W = 32,
    parameter logic [31:0] KEEP  = 32'h0
) (
    input  logic [MSR_W-1:0] msr_i,
    output logic [MSR_W-1:0] msr_o
);
    for (genvar b = 0; b < MSR_W; b++) begin : g_bit
        if (KEEP[b]) begin : g_keep
            assign msr_o[b] = msr_i[b];
        end else begin : g_clear
            assign msr_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/atu_vector_gen.sv
module atu_vector_gen #(
    parameter int PFX_W  = 16,
    parameter int OFS_W  = 12,
    parameter int ZERO_W = 4,
    localparam int TGT_W = PFX_W + OFS_W + ZERO_W
) (
    input  logic [PFX_W-1:0] prefix_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [TGT_W-1:0] target_o
);
    assign target_o = {prefix_i, offset_i, {ZERO_W{1'b0}}};
endmodule

// File: rtl/align_trap_unit.sv
module align_trap_unit
    import atu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MSR_W  = 32,
    parameter int PFX_W  = 16,
    parameter int OFS_W  = 12,
    parameter int ZERO_W = 4,
    parameter int CE_BIT = 17,
    parameter int ME_BIT = 12,
    parameter int DE_BIT = 9
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take_i,
    input  logic [ADDR_W-1:0]             inst_ea_i,
    input  logic [ADDR_W-1:0]             data_ea_i,
    input  logic [MSR_W-1:0]              msr_i,
    input  logic [PFX_W-1:0]              vec_prefix_i,
    input  logic [OFS_W-1:0]              vec_offset_i,
    output logic                          squash_o,
    output logic [ADDR_W-1:0]             saved_pc_o,
    output logic [MSR_W-1:0]              saved_msr_o,
    output logic [ADDR_W-1:0]             fault_addr_o,
    output logic [MSR_W-1:0]              msr_o,
    output logic                          redirect_o,
    output logic [PFX_W+OFS_W+ZERO_W-1:0] target_o
);
    localparam int          TGT_W = PFX_W + OFS_W + ZERO_W;
    localparam logic [31:0] KEEP  = keep_mask(CE_BIT, ME_BIT, DE_BIT);

    logic             capture;
    logic [MSR_W-1:0] msr_filt;
    logic [TGT_W-1:0] tgt_next;

    atu_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .take_i     (take_i),
        .capture_o  (capture),
        .squash_o   (squash_o),
        .redirect_o (redirect_o)
    );

    atu_msr_filter #(.MSR_W(MSR_W), .KEEP(KEEP)) u_filter (
        .msr_i (msr_i),
        .msr_o (msr_filt)
    );

    atu_vector_gen #(.PFX_W(PFX_W), .OFS_W(OFS_W), .ZERO_W(ZERO_W)) u_vec (
        .prefix_i (vec_prefix_i),
        .offset_i (vec_offset_i),
        .target_o (tgt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_pc_o   <= '0;
            saved_msr_o  <= '0;
            fault_addr_o <= '0;
            msr_o        <= '0;
            target_o     <= '0;
        end else if (capture) begin
            saved_pc_o   <= inst_ea_i;
            saved_msr_o  <= msr_i;
            fault_addr_o <= data_ea_i;
            msr_o        <= msr_filt;
            target_o     <= tgt_next;
        end
    end

    AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        take_i |=> saved_pc_o == $past(inst_ea_i)); // R3
    AST_MSR_SAVE: assert property (@(posedge clk) disable iff (rst)
        take_i |=> saved_msr_o == $past(msr_i)); // R4
    AST_MSR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (msr_o & ~KEEP[MSR_W-1:0]) == '0); // R5
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
        take_i |=> fault_addr_o == $past(data_ea_i)); // R6
    AST_TARGET_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        take_i |=> target_o[ZERO_W-1:0] == '0); // R7
    AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(saved_pc_o) && $stable(saved_msr_o) && $stable(fault_addr_o)
                    && $stable(msr_o) && $stable(target_o)); // R9
endmodule

// File: tb/align_trap_unit_tb.sv
module align_trap_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEEPM = (32'h1 << 17) | (32'h1 << 12) | (32'h1 << 9);

    logic        clk = 1'b0;
    logic        rst;
    logic        take_i;
    logic [31:0] inst_ea_i, data_ea_i, msr_i;
    logic [15:0] vec_prefix_i;
    logic [11:0] vec_offset_i;
    logic        squash_o, redirect_o;
    logic [31:0] saved_pc_o, saved_msr_o, fault_addr_o, msr_o, target_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    align_trap_unit dut_i (
        .clk(clk), .rst(rst), .take_i(take_i),
        .inst_ea_i(inst_ea_i), .data_ea_i(data_ea_i), .msr_i(msr_i),
        .vec_prefix_i(vec_prefix_i), .vec_offset_i(vec_offset_i),
        .squash_o(squash_o), .saved_pc_o(saved_pc_o), .saved_msr_o(saved_msr_o),
        .fault_addr_o(fault_addr_o), .msr_o(msr_o), .redirect_o(redirect_o),
        .target_o(target_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic [31:0] ia, input logic [31:0] da,
                         input logic [31:0] m, input logic [15:0] p, input logic [11:0] o);
        take_i = t; inst_ea_i = ia; data_ea_i = da; msr_i = m;
        vec_prefix_i = p; vec_offset_i = o;
    endtask

    task automatic check_capture(input logic [31:0] ia, input logic [31:0] da,
                                 input logic [31:0] m, input logic [15:0] p, input logic [11:0] o);
        chk("R3 saved pc", saved_pc_o, ia);
        chk("R4 saved msr", saved_msr_o, m);
        chk("R5 new msr", msr_o, m & KEEPM);
        chk("R6 fault addr", fault_addr_o, da);
        chk("R7 target", target_o, {p, o, 4'b0000});
    endtask

    task automatic test_reset();
        rst = 1'b1;
        drive(1'b0, '0, '0, '0, '0, '0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 saved pc", saved_pc_o, 0);
        chk("R1 saved msr", saved_msr_o, 0);
        chk("R1 fault addr", fault_addr_o, 0);
        chk("R1 msr", msr_o, 0);
        chk("R1 target", target_o, 0);
        chk("R1 redirect", {31'b0, redirect_o}, 0);
        chk("R2 squash idle", {31'b0, squash_o}, 0);
    endtask

    task automatic test_single(input logic [31:0] ia, input logic [31:0] da,
                               input logic [31:0] m, input logic [15:0] p, input logic [11:0] o);
        @(negedge clk);
        drive(1'b1, ia, da, m, p, o);
        #1;
        chk("R2 squash with take", {31'b0, squash_o}, 1);
        chk("R8 no redirect yet", {31'b0, redirect_o}, 0);
        @(negedge clk);
        take_i = 1'b0;
        #1;
        chk("R2 squash drops", {31'b0, squash_o}, 0);
        chk("R8 redirect pulse", {31'b0, redirect_o}, 1);
        check_capture(ia, da, m, p, o);
        @(negedge clk);
        chk("R8 redirect one cycle", {31'b0, redirect_o}, 0);
    endtask

    task automatic test_hold();
        logic [31:0] pc0, sm0, fa0, m0, t0;
        pc0 = saved_pc_o; sm0 = saved_msr_o; fa0 = fault_addr_o; m0 = msr_o; t0 = target_o;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive(1'b0, 32'h1111_0000 + i, 32'h2222_0000 + i, 32'hFFFF_FFFF, 16'hBEEF, 12'hACE);
        end
        @(negedge clk);
        chk("R9 pc held", saved_pc_o, pc0);
        chk("R9 msr saved held", saved_msr_o, sm0);
        chk("R9 fault held", fault_addr_o, fa0);
        chk("R9 msr held", msr_o, m0);
        chk("R9 target held", target_o, t0);
        chk("R9 no redirect", {31'b0, redirect_o}, 0);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        drive(1'b1, 32'h0000_1000, 32'h0000_2003, 32'h0002_1200, 16'h1234, 12'h056);
        @(negedge clk);
        drive(1'b1, 32'h0000_1004, 32'h0000_3007, 32'hFFFD_EDFF, 16'h5678, 12'h0A0);
        #1;
        chk("R10 first redirect", {31'b0, redirect_o}, 1);
        chk("R10 first pc", saved_pc_o, 32'h0000_1000);
        @(negedge clk);
        take_i = 1'b0;
        #1;
        chk("R10 second redirect", {31'b0, redirect_o}, 1);
        chk("R10 second pc", saved_pc_o, 32'h0000_1004);
        check_capture(32'h0000_1004, 32'h0000_3007, 32'hFFFD_EDFF, 16'h5678, 12'h0A0);
        @(negedge clk);
        chk("R10 redirect ends", {31'b0, redirect_o}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_single(32'h0000_0104, 32'h0000_8003, 32'hFFFF_FFFF, 16'hFFF0, 12'h050);
        test_single(32'h8000_2000, 32'h0000_1FF5, 32'h0002_1200, 16'h0001, 12'hFFF);
        test_single(32'hDEAD_BEE0, 32'h1234_567F, 32'hFFFD_EDFF, 16'hA5A5, 12'h000);
        test_hold();
        test_back_to_back();
        test_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule